// File: doc/BRIEF.md
# Vertical Column Defect Corrector

This block repairs a raw sensor pixel stream in which up to eight columns are known to be bad. A small table is loaded through a configuration port before a frame. Each entry names a defective column and the row where the defect begins. It also holds three 8-bit levels: one for the defect row itself, one for the rows above it and one for the rows below it. The block counts rows and columns from the frame-valid and line-valid strobes. When the centre pixel lies on an active defect column, the block corrects it. Pixels on other columns pass through unchanged.

Correction works in one of three ways. The block can subtract the row-dependent level, shifted left by a programmed amount. It can replace the pixel with the average of the pixels two places to its left and two places to its right. It can also choose between these two according to a programmable saturation threshold. A five-tap delay line supplies the two neighbours. At the ends of a line, the nearest pixel that exists in that line takes the place of a missing neighbour.

Top module: `vcol_fix`

## Requirements
- R1: While reset is high, and on the first clock after reset is released, out_lv and out_pix are 0 regardless of the inputs.
- R2: Each pixel sampled with pix_lv high is presented at out_pix with out_lv high exactly 4 clock cycles later, in input order. A pixel on a column that matches no active entry is presented unchanged. Lines within a frame (pix_fv high) must be separated by at least 2 cycles with pix_lv low. The row counter starts at 0 in each frame and advances when pix_lv falls.
- R3: Only entries whose index is below cfg_count take part. Entries at or above cfg_count have no effect. A cfg_count of 8 or more activates all entries, and a cfg_count of 0 disables correction.
- R4: For a matching entry, the block uses the "at" level on the entry's row, the "up" level on rows with a smaller index, and the "down" level on rows with a larger index.
- R5: The selected level is shifted left by cfg_shift before it is used. Values of cfg_shift above 4 act as 4.
- R6: A subtraction that would go below zero gives 0.
- R7: With cfg_mode 0 (or 3), the block subtracts the level. A pixel at or above cfg_sat passes unchanged.
- R8: With cfg_mode 1, the block subtracts the level. A pixel at or above cfg_sat is replaced by floor((p[c-2]+p[c+2])/2).
- R9: With cfg_mode 2, every corrected pixel is replaced by floor((p[c-2]+p[c+2])/2). At a line edge, a missing neighbour takes the value of the nearest pixel of the same line: for column 0 both left taps use p[0], for column 1 the left tap uses p[0], and the right taps mirror this at the last column.
- R10: With cfg_whole 0, pixels on rows above the entry's row are left uncorrected in every mode. With cfg_whole 1, every row of the column is corrected.
- R11: When several active entries name the same column, the entry with the lowest index applies.
- R12: When out_lv is low, out_pix is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 12 | Input pixel |
| pix_lv | input | 1 | Line valid: pix_in holds a pixel this cycle |
| pix_fv | input | 1 | Frame valid; low resets the row count |
| cfg_we | input | 1 | Write strobe for one table entry |
| cfg_idx | input | 3 | Table entry index for a write |
| cfg_row | input | 13 | Row where the defect starts |
| cfg_col | input | 13 | Defective column |
| cfg_lvl_at | input | 8 | Level used on the defect row |
| cfg_lvl_up | input | 8 | Level used above the defect row |
| cfg_lvl_dn | input | 8 | Level used below the defect row |
| cfg_count | input | 4 | Number of active entries |
| cfg_mode | input | 2 | 0/3 subtract, 1 subtract with interpolation fallback, 2 interpolate |
| cfg_whole | input | 1 | 1 corrects the whole column, 0 skips rows above the defect |
| cfg_shift | input | 3 | Left shift applied to levels (0 to 4) |
| cfg_sat | input | 12 | Saturation threshold |
| out_pix | output | 12 | Corrected pixel |
| out_lv | output | 1 | Output line valid |
| out_fv | output | 1 | Output frame valid |

## Verification
The bound assertions check on every cycle the four-cycle line-valid latency, the zero output during idle cycles, and transparency when the table is disabled. They also check that subtract mode never raises a pixel above its input. Level choice by row, shifting, clamping, the saturation fallback, edge replication of the neighbours, entry priority and the skip-above control all depend on table contents and pixel values. Only the bench scenarios show these, by comparing every output pixel against a model built from the requirements.

// File: rtl/vcol_pkg.sv
package vcol_pkg;

  typedef enum logic [1:0] {
    MD_SUB        = 2'd0,
    MD_SUB_INTERP = 2'd1,
    MD_INTERP     = 2'd2,
    MD_SUB_ALT    = 2'd3
  } vcol_mode_e;

  typedef enum logic [1:0] {
    RG_AT = 2'd0,
    RG_UP = 2'd1,
    RG_DN = 2'd2
  } vcol_region_e;

endpackage

// File: rtl/vcol_window.sv
module vcol_window #(
  parameter int PIX_W = 12,
  parameter int POS_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             pix_lv,
  input  logic             pix_fv,
  output logic [PIX_W-1:0] ctr_pix,
  output logic [PIX_W-1:0] left_pix,
  output logic [PIX_W-1:0] right_pix,
  output logic             ctr_vld,
  output logic             ctr_fv,
  output logic [POS_W-1:0] ctr_row,
  output logic [POS_W-1:0] ctr_col
);
  localparam int TAPS = 5;
  localparam int MID  = TAPS / 2;
  localparam int STG  = MID + 1;

  logic [PIX_W-1:0] tap_d [TAPS];
  logic [TAPS-1:0]  tap_v;
  logic [POS_W-1:0] row_cnt, col_cnt;
  logic             lv_q;
  logic [POS_W-1:0] row_p [STG];
  logic [POS_W-1:0] col_p [STG];
  logic [STG-1:0]   fv_p;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_cnt <= '0;
      col_cnt <= '0;
      lv_q    <= 1'b0;
      tap_v   <= '0;
      fv_p    <= '0;
      for (int k = 0; k < TAPS; k++) tap_d[k] <= '0;
      for (int k = 0; k < STG; k++) begin
        row_p[k] <= '0;
        col_p[k] <= '0;
      end
    end else begin
      lv_q    <= pix_lv;
      col_cnt <= pix_lv ? col_cnt + 1'b1 : '0;
      if (!pix_fv)
        row_cnt <= '0;
      else if (lv_q && !pix_lv)
        row_cnt <= row_cnt + 1'b1;
      tap_d[0] <= pix_in;
      for (int k = 1; k < TAPS; k++) tap_d[k] <= tap_d[k-1];
      tap_v    <= {tap_v[TAPS-2:0], pix_lv};
      row_p[0] <= row_cnt;
      col_p[0] <= col_cnt;
      for (int k = 1; k < STG; k++) begin
        row_p[k] <= row_p[k-1];
        col_p[k] <= col_p[k-1];
      end
      fv_p <= {fv_p[STG-2:0], pix_fv};
    end
  end

  // Older samples sit at higher tap indices (left of centre).
  assign ctr_pix   = tap_d[MID];
  assign ctr_vld   = tap_v[MID];
  assign ctr_fv    = fv_p[STG-1];
  assign ctr_row   = row_p[STG-1];
  assign ctr_col   = col_p[STG-1];
  assign left_pix  = tap_v[MID+2] ? tap_d[MID+2] :
                     tap_v[MID+1] ? tap_d[MID+1] : tap_d[MID];
  assign right_pix = tap_v[MID-2] ? tap_d[MID-2] :
                     tap_v[MID-1] ? tap_d[MID-1] : tap_d[MID];
endmodule

// File: rtl/vcol_table.sv
module vcol_table
  import vcol_pkg::*;
#(
  parameter int NUM_DEF = 8,
  parameter int POS_W   = 13,
  parameter int LVL_W   = 8,
  localparam int IDX_W  = $clog2(NUM_DEF),
  localparam int CNT_W  = $clog2(NUM_DEF + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [POS_W-1:0] cfg_row,
  input  logic [POS_W-1:0] cfg_col,
  input  logic [LVL_W-1:0] cfg_lvl_at,
  input  logic [LVL_W-1:0] cfg_lvl_up,
  input  logic [LVL_W-1:0] cfg_lvl_dn,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [POS_W-1:0] q_row,
  input  logic [POS_W-1:0] q_col,
  output logic             hit,
  output vcol_region_e     region,
  output logic [LVL_W-1:0] lvl
);
  logic [POS_W-1:0] ent_row [NUM_DEF];
  logic [POS_W-1:0] ent_col [NUM_DEF];
  logic [LVL_W-1:0] ent_at  [NUM_DEF];
  logic [LVL_W-1:0] ent_up  [NUM_DEF];
  logic [LVL_W-1:0] ent_dn  [NUM_DEF];
  logic [NUM_DEF-1:0] match;
  logic [IDX_W-1:0]   sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NUM_DEF; k++) begin
        ent_row[k] <= '0;
        ent_col[k] <= '0;
        ent_at[k]  <= '0;
        ent_up[k]  <= '0;
        ent_dn[k]  <= '0;
      end
    end else if (cfg_we) begin
      ent_row[cfg_idx] <= cfg_row;
      ent_col[cfg_idx] <= cfg_col;
      ent_at[cfg_idx]  <= cfg_lvl_at;
      ent_up[cfg_idx]  <= cfg_lvl_up;
      ent_dn[cfg_idx]  <= cfg_lvl_dn;
    end
  end

  for (genvar k = 0; k < NUM_DEF; k++) begin : g_cmp
    assign match[k] = (CNT_W'(k) < cfg_count) && (ent_col[k] == q_col);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    sel = '0;
    for (int k = NUM_DEF - 1; k >= 0; k--)
      if (match[k]) sel = IDX_W'(k);
  end

  always_comb begin
    hit = |match;
    if (q_row == ent_row[sel])     region = RG_AT;
    else if (q_row < ent_row[sel]) region = RG_UP;
    else                           region = RG_DN;
    case (region)
      RG_AT:   lvl = ent_at[sel];
      RG_UP:   lvl = ent_up[sel];
      default: lvl = ent_dn[sel];
    endcase
  end
endmodule

// File: rtl/vcol_alu.sv
module vcol_alu
  import vcol_pkg::*;
#(
  parameter int PIX_W  = 12,
  parameter int LVL_W  = 8,
  parameter int SH_MAX = 4,
  localparam int SH_W  = $clog2(SH_MAX + 1),
  localparam int AW    = (PIX_W > LVL_W + SH_MAX) ? PIX_W : LVL_W + SH_MAX
) (
  input  logic [PIX_W-1:0] ctr_pix,
  input  logic [PIX_W-1:0] left_pix,
  input  logic [PIX_W-1:0] right_pix,
  input  logic             hit,
  input  vcol_region_e     region,
  input  logic [LVL_W-1:0] lvl,
  input  vcol_mode_e       mode,
  input  logic             whole,
  input  logic [SH_W-1:0]  shift,
  input  logic [PIX_W-1:0] sat,
  output logic [PIX_W-1:0] res
);
  logic [SH_W-1:0]  sh;
  logic [AW-1:0]    amt, ctr_w, diff;
  logic [PIX_W-1:0] sub_pix, avg_pix, fixed;
  logic [PIX_W:0]   nsum;
  logic             act, is_sat;

  always_comb begin
    sh      = (shift > SH_W'(SH_MAX)) ? SH_W'(SH_MAX) : shift;
    amt     = AW'(lvl) << sh;
    ctr_w   = AW'(ctr_pix);
    diff    = (ctr_w >= amt) ? ctr_w - amt : '0;
    sub_pix = PIX_W'(diff);
    nsum    = {1'b0, left_pix} + {1'b0, right_pix};
    avg_pix = nsum[PIX_W:1];
    is_sat  = ctr_pix >= sat;
    act     = hit && !((region == RG_UP) && !whole);
    case (mode)
      MD_SUB_INTERP: fixed = is_sat ? avg_pix : sub_pix;
      MD_INTERP:     fixed = avg_pix;
      default:       fixed = is_sat ? ctr_pix : sub_pix;
    endcase
    res = act ? fixed : ctr_pix;
  end
endmodule

// File: rtl/vcol_fix.sv
module vcol_fix
  import vcol_pkg::*;
#(
  parameter int PIX_W   = 12,
  parameter int POS_W   = 13,
  parameter int LVL_W   = 8,
  parameter int NUM_DEF = 8,
  parameter int SH_MAX  = 4,
  localparam int IDX_W  = $clog2(NUM_DEF),
  localparam int CNT_W  = $clog2(NUM_DEF + 1),
  localparam int SH_W   = $clog2(SH_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             pix_lv,
  input  logic             pix_fv,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [POS_W-1:0] cfg_row,
  input  logic [POS_W-1:0] cfg_col,
  input  logic [LVL_W-1:0] cfg_lvl_at,
  input  logic [LVL_W-1:0] cfg_lvl_up,
  input  logic [LVL_W-1:0] cfg_lvl_dn,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_whole,
  input  logic [SH_W-1:0]  cfg_shift,
  input  logic [PIX_W-1:0] cfg_sat,
  output logic [PIX_W-1:0] out_pix,
  output logic             out_lv,
  output logic             out_fv
);
  logic [PIX_W-1:0] ctr_pix, left_pix, right_pix, fixed_pix;
  logic             ctr_vld, ctr_fv, hit;
  logic [POS_W-1:0] ctr_row, ctr_col;
  vcol_region_e     region;
  logic [LVL_W-1:0] lvl;

  vcol_window #(.PIX_W(PIX_W), .POS_W(POS_W)) u_win (
    .clk(clk), .rst(rst), .pix_in(pix_in), .pix_lv(pix_lv), .pix_fv(pix_fv),
    .ctr_pix(ctr_pix), .left_pix(left_pix), .right_pix(right_pix),
    .ctr_vld(ctr_vld), .ctr_fv(ctr_fv), .ctr_row(ctr_row), .ctr_col(ctr_col)
  );

  vcol_table #(.NUM_DEF(NUM_DEF), .POS_W(POS_W), .LVL_W(LVL_W)) u_tab (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_row(cfg_row), .cfg_col(cfg_col), .cfg_lvl_at(cfg_lvl_at),
    .cfg_lvl_up(cfg_lvl_up), .cfg_lvl_dn(cfg_lvl_dn), .cfg_count(cfg_count),
    .q_row(ctr_row), .q_col(ctr_col), .hit(hit), .region(region), .lvl(lvl)
  );

  vcol_alu #(.PIX_W(PIX_W), .LVL_W(LVL_W), .SH_MAX(SH_MAX)) u_alu (
    .ctr_pix(ctr_pix), .left_pix(left_pix), .right_pix(right_pix),
    .hit(hit), .region(region), .lvl(lvl), .mode(vcol_mode_e'(cfg_mode)),
    .whole(cfg_whole), .shift(cfg_shift), .sat(cfg_sat), .res(fixed_pix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_pix <= '0;
      out_lv  <= 1'b0;
      out_fv  <= 1'b0;
    end else begin
      out_lv  <= ctr_vld;
      out_fv  <= ctr_fv;
      out_pix <= ctr_vld ? fixed_pix : '0;
    end
  end
endmodule

// File: rtl/vcol_fix_chk.sv
module vcol_fix_chk #(
  parameter int PIX_W   = 12,
  parameter int NUM_DEF = 8,
  localparam int CNT_W  = $clog2(NUM_DEF + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [PIX_W-1:0] pix_in,
  input logic             pix_lv,
  input logic [CNT_W-1:0] cfg_count,
  input logic [1:0]       cfg_mode,
  input logic [PIX_W-1:0] out_pix,
  input logic             out_lv
);
  logic [2:0] age;
  logic       warm;

  always_ff @(posedge clk) begin
    if (rst)             age <= '0;
    else if (age != 3'd4) age <= age + 1'b1;
  end
  assign warm = (age == 3'd4);

  // R2
  lat_lv_chk: assert property (@(posedge clk) disable iff (rst)
    warm |-> (out_lv == $past(pix_lv, 4)));

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_lv |-> (out_pix == '0));

  // R3
  off_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (warm && out_lv && $past(cfg_count, 1) == '0) |-> (out_pix == $past(pix_in, 4)));

  // R7
  sub_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (warm && out_lv && $past(cfg_mode, 1) == 2'd0) |-> (out_pix <= $past(pix_in, 4)));
endmodule

bind vcol_fix vcol_fix_chk #(.PIX_W(PIX_W), .NUM_DEF(NUM_DEF)) u_chk (
  .clk(clk), .rst(rst), .pix_in(pix_in), .pix_lv(pix_lv),
  .cfg_count(cfg_count), .cfg_mode(cfg_mode), .out_pix(out_pix), .out_lv(out_lv)
);

// File: tb/test_vcol_fix.sv
module test_vcol_fix;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] pix_in = '0;
  logic        pix_lv = 1'b0, pix_fv = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0;
  logic [12:0] cfg_row = '0, cfg_col = '0;
  logic [7:0]  cfg_lvl_at = '0, cfg_lvl_up = '0, cfg_lvl_dn = '0;
  logic [3:0]  cfg_count = '0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_whole = 1'b1;
  logic [2:0]  cfg_shift = '0;
  logic [11:0] cfg_sat = 12'd3000;
  logic [11:0] out_pix;
  logic        out_lv, out_fv;

  vcol_fix i_vcol_fix (.*);

  always #2 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int exp_q[$];
  string tag_q[$];
  int m_row[8], m_col[8], m_at[8], m_up[8], m_dn[8];
  int m_cnt = 0, m_mode = 0, m_whole = 1, m_shift = 0, m_sat = 3000;
  int line_px[0:63];
  int ov_c = -1, ov_v = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model(int r, int c, int n);
    int hit = -1, lv, sh, amt, px, lft, rgt, avg, sub;
    px = line_px[c];
    for (int k = 0; k < 8; k++)
      if (k < m_cnt && m_col[k] == c && hit < 0) hit = k;
    if (hit < 0) return px;
    if (r < m_row[hit] && m_whole == 0) return px;
    lv = (r == m_row[hit]) ? m_at[hit] : (r < m_row[hit]) ? m_up[hit] : m_dn[hit];
    sh = (m_shift > 4) ? 4 : m_shift;
    amt = lv << sh;
    sub = (px >= amt) ? px - amt : 0;
    lft = (c >= 2) ? line_px[c-2] : line_px[0];
    rgt = (c + 2 <= n - 1) ? line_px[c+2] : line_px[n-1];
    avg = (lft + rgt) / 2;
    case (m_mode)
      1: return (px >= m_sat) ? avg : sub;
      2: return avg;
      default: return (px >= m_sat) ? px : sub;
    endcase
  endfunction

  // Monitor: pop and compare every produced pixel.
  always @(negedge clk) begin
    if (!rst && out_lv && !done) begin
      if (exp_q.size() == 0) chk("R2 unexpected output", 1, 0);
      else chk(tag_q.pop_front(), int'(out_pix), exp_q.pop_front());
    end
  end

  task automatic wr_entry(int i, int r, int c, int at, int up, int dn);
    cfg_we = 1; cfg_idx = 3'(i); cfg_row = 13'(r); cfg_col = 13'(c);
    cfg_lvl_at = 8'(at); cfg_lvl_up = 8'(up); cfg_lvl_dn = 8'(dn);
    @(negedge clk);
    cfg_we = 0;
    m_row[i] = r; m_col[i] = c; m_at[i] = at; m_up[i] = up; m_dn[i] = dn;
  endtask

  task automatic set_ctl(int cnt, int md, int wh, int sh, int st);
    cfg_count = 4'(cnt); cfg_mode = 2'(md); cfg_whole = wh[0];
    cfg_shift = 3'(sh); cfg_sat = 12'(st);
    m_cnt = cnt; m_mode = md; m_whole = wh; m_shift = sh; m_sat = st;
    @(negedge clk);
  endtask

  task automatic send_line(int r, int n, string tag);
    for (int c = 0; c < n; c++) begin
      exp_q.push_back(model(r, c, n));
      tag_q.push_back(tag);
      pix_lv = 1; pix_in = 12'(line_px[c]);
      @(negedge clk);
    end
    pix_lv = 0; pix_in = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_frame(int rows, int n, int seed, string tag);
    pix_fv = 1;
    @(negedge clk);
    for (int r = 0; r < rows; r++) begin
      for (int c = 0; c < n; c++) line_px[c] = (40 + 53 * c + 11 * r + seed) % 2900 + 30;
      if (ov_c >= 0) line_px[ov_c] = ov_v;
      send_line(r, n, tag);
    end
    pix_fv = 0;
    repeat (8) @(negedge clk);
    chk("R12 idle output", int'(out_pix) + int'(out_lv), 0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    done = 1;
    summary();
  end

  initial begin
    // R1: reset dominates live inputs
    pix_lv = 1; pix_fv = 1; pix_in = 12'd555;
    repeat (4) @(negedge clk);
    chk("R1 reset out_lv", int'(out_lv), 0);
    chk("R1 reset out_pix", int'(out_pix), 0);
    rst = 0;
    pix_lv = 0; pix_fv = 0; pix_in = '0;
    @(negedge clk);
    chk("R1 after release out_lv", int'(out_lv), 0);
    chk("R1 after release out_pix", int'(out_pix), 0);
    repeat (6) @(negedge clk);

    // R2: exact latency of a lone pixel, table off
    pix_fv = 1; pix_lv = 1; pix_in = 12'd77;
    line_px[0] = 77;
    exp_q.push_back(77); tag_q.push_back("R2 lone pixel");
    @(negedge clk);
    pix_lv = 0; pix_in = '0;
    repeat (2) @(negedge clk);
    chk("R2 latency not yet", int'(out_lv), 0);
    @(negedge clk);
    chk("R2 latency arrival", int'(out_lv), 1);
    pix_fv = 0;
    repeat (6) @(negedge clk);

    wr_entry(0, 3, 5, 10, 20, 30);
    wr_entry(1, 1, 9, 7, 3, 200);
    wr_entry(2, 0, 0, 4, 4, 4);
    wr_entry(3, 0, 5, 99, 99, 99);   // R11: same column as entry 0
    wr_entry(4, 2, 14, 5, 6, 8);
    wr_entry(5, 2, 1, 9, 2, 12);
    wr_entry(6, 0, 12, 60, 60, 60);  // R3: outside count 6
    wr_entry(7, 0, 3, 60, 60, 60);   // R3: outside count 6

    // R2: plain pass-through with table disabled
    set_ctl(0, 0, 1, 0, 3000);
    run_frame(3, 16, 0, "R2 passthrough");
    // R4 R6 R11 R3: level by region, clamp, priority, inactive entries
    set_ctl(6, 0, 1, 0, 3000);
    ov_c = 9; ov_v = 150;
    run_frame(5, 16, 7, "R4 R6 R11 R3 subtract");
    ov_c = -1;
    // R5: shifted levels, and shift above 4 acting as 4
    set_ctl(6, 0, 1, 3, 3000);
    run_frame(5, 16, 3, "R5 shift 3");
    set_ctl(6, 0, 1, 7, 3000);
    run_frame(5, 16, 5, "R5 shift clamp");
    // R7: saturated pixel passes in mode 0 and mode 3
    ov_c = 5; ov_v = 3500;
    set_ctl(6, 0, 1, 0, 3000);
    run_frame(5, 16, 2, "R7 mode0 saturated");
    set_ctl(6, 3, 1, 0, 3000);
    run_frame(5, 16, 4, "R7 mode3 saturated");
    // R8: saturated pixel interpolated in mode 1
    set_ctl(6, 1, 1, 0, 3000);
    run_frame(5, 16, 6, "R8 mode1 fallback");
    ov_c = -1;
    set_ctl(6, 1, 1, 0, 3000);
    run_frame(4, 16, 8, "R8 mode1 below sat");
    // R9: interpolation including both line edges and a short line
    set_ctl(6, 2, 1, 0, 3000);
    run_frame(5, 16, 9, "R9 interpolate");
    run_frame(3, 3, 1, "R9 short line");
    // R10: rows above the defect left alone
    set_ctl(6, 2, 0, 0, 3000);
    run_frame(5, 16, 10, "R10 skip above mode2");
    set_ctl(6, 0, 0, 2, 3000);
    run_frame(5, 16, 11, "R10 skip above mode0");
    // R3: count above 8 activates all entries
    set_ctl(9, 0, 1, 0, 3000);
    run_frame(4, 16, 12, "R3 count over 8");

    repeat (10) @(negedge clk);
    chk("R2 all outputs produced", exp_q.size(), 0);
    done = 1;
    summary();
  end
endmodule